// File: doc/BRIEF.md
# Fault Isolation Register with Attention Routing

This block collects the error reports of one chip region into a 64-bit fault register. Each bit belongs to one independent error source. A one-cycle pulse from a source sets its bit, and the bit stays set until software clears it. Software reaches the block over a simple register bus that has an address, a write enable, a read enable, write data, registered read data and a read-valid flag. Besides the fault register there is a mask register and two action registers. Four write-only alias addresses set bits (OR) or clear bits (AND) in the fault and mask registers in one bus write, without a read-modify-write sequence.

Each fault bit that is set and not masked is routed by its pair of action bits to one of three registered attention outputs. Both action bits clear gives a checkstop. Action1 set with action0 clear gives a recoverable attention. Action0 set gives a local attention, so that no unmasked fault is lost. After reset every fault is masked, and software enables sources by clearing mask bits.

Top module: `fir_attn_top`

## Requirements
- R1: After reset the fault register and both action registers read zero, the mask register reads all ones, and all three attention outputs are low.
- R2: A high bit on `err_pulse` sets the matching fault bit at the next clock edge. The bit stays set with no further pulse until software clears it.
- R3: A write at offset 0x0A replaces the fault register. A write at 0x0C ORs the write data into it. A write at 0x0B ANDs it with the write data, which clears exactly the bits written as zero.
- R4: A write at offset 0x0D replaces the mask register, 0x0F ORs the write data into it, and 0x0E ANDs it with the write data. Writes at 0x10 and 0x11 replace action0 and action1.
- R5: When a software write (direct or AND alias) would clear a fault bit in the same cycle as a hardware pulse on that bit, the bit ends up set.
- R6: `attn_checkstop` is high when some bit is set in fault, clear in mask, clear in action0 and clear in action1.
- R7: `attn_recoverable` is high when some bit is set in fault, clear in mask, clear in action0 and set in action1.
- R8: `attn_local` is high when some bit is set in fault, clear in mask and set in action0, whatever its action1 bit.
- R9: A read enable at a clock edge gives `bus_rvalid` high and `bus_rdata` holding the addressed register's value from before that edge, one cycle later. Reads from the alias offsets 0x0B, 0x0C, 0x0E, 0x0F or from an unmapped offset return zero.
- R10: Writes to offsets other than 0x0A to 0x11 change no register.
- R11: The attention outputs are registered. They reflect the register contents one clock cycle after the edge at which a write or a pulse changed those registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Register offset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_wdata | input | W (64) | Write data |
| bus_rdata | output | W (64) | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| err_pulse | input | W (64) | Per-bit error source pulses |
| attn_checkstop | output | 1 | Checkstop attention |
| attn_recoverable | output | 1 | Recoverable attention |
| attn_local | output | 1 | Local attention from faults with action0 set |

## Verification
The assertions check the following on every cycle: the reset values, that a pulse sets its bit even during a clearing write, the result of an AND-alias write, that an unmapped write leaves every register alone, that alias reads return zero, and that each attention rises only when the previous cycle held a matching fault. Other behaviours depend on the history of several writes, and only the bench scenarios show them. Examples are a bit staying set across idle cycles, correct routing after software changes the mask or action bits, and read data that matches the value before the same edge. A reference model in the bench, updated every cycle under random and directed traffic, checks these.

// File: rtl/fir_pkg.sv
package fir_pkg;

  typedef enum logic [3:0] {
    RS_NONE, RS_FAULT, RS_FAULT_AND, RS_FAULT_OR,
    RS_MASK, RS_MASK_AND, RS_MASK_OR, RS_ACT0, RS_ACT1
  } reg_sel_e;

  localparam logic [31:0] OFF_FAULT     = 32'h0A;
  localparam logic [31:0] OFF_FAULT_AND = 32'h0B;
  localparam logic [31:0] OFF_FAULT_OR  = 32'h0C;
  localparam logic [31:0] OFF_MASK      = 32'h0D;
  localparam logic [31:0] OFF_MASK_AND  = 32'h0E;
  localparam logic [31:0] OFF_MASK_OR   = 32'h0F;
  localparam logic [31:0] OFF_ACT0      = 32'h10;
  localparam logic [31:0] OFF_ACT1      = 32'h11;

  function automatic reg_sel_e decode_offset(input logic [31:0] off);
    case (off)
      OFF_FAULT:     return RS_FAULT;
      OFF_FAULT_AND: return RS_FAULT_AND;
      OFF_FAULT_OR:  return RS_FAULT_OR;
      OFF_MASK:      return RS_MASK;
      OFF_MASK_AND:  return RS_MASK_AND;
      OFF_MASK_OR:   return RS_MASK_OR;
      OFF_ACT0:      return RS_ACT0;
      OFF_ACT1:      return RS_ACT1;
      default:       return RS_NONE;
    endcase
  endfunction

  function automatic logic is_alias(input reg_sel_e s);
    return (s == RS_FAULT_AND) || (s == RS_FAULT_OR) ||
           (s == RS_MASK_AND)  || (s == RS_MASK_OR);
  endfunction

endpackage

// File: rtl/fir_bus_decode.sv
module fir_bus_decode
  import fir_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output reg_sel_e          wr_sel,
  output reg_sel_e          rd_sel
);

  reg_sel_e hit;

  always_comb begin
    hit    = decode_offset(32'(addr));
    wr_sel = wr_en ? hit : RS_NONE;
    rd_sel = rd_en ? hit : RS_NONE;
  end

endmodule

// File: rtl/fir_store.sv
module fir_store
  import fir_pkg::*;
#(
  parameter int W       = 64,
  parameter int NUM_ACT = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  reg_sel_e                    wr_sel,
  input  reg_sel_e                    rd_sel,
  input  logic                        rd_en,
  input  logic [W-1:0]                wdata,
  input  logic [W-1:0]                err_pulse,
  output logic [W-1:0]                fault_q,
  output logic [W-1:0]                mask_q,
  output logic [NUM_ACT-1:0][W-1:0]   act_q,
  output logic [W-1:0]                rdata,
  output logic                        rvalid
);

  logic [W-1:0] fault_sw, fault_d, mask_d, rd_val;

  // Software update of the fault register, then hardware sets win (R5)
  always_comb begin
    case (wr_sel)
      RS_FAULT:     fault_sw = wdata;
      RS_FAULT_AND: fault_sw = fault_q & wdata;
      RS_FAULT_OR:  fault_sw = fault_q | wdata;
      default:      fault_sw = fault_q;
    endcase
    fault_d = fault_sw | err_pulse;
  end

  always_comb begin
    case (wr_sel)
      RS_MASK:     mask_d = wdata;
      RS_MASK_AND: mask_d = mask_q & wdata;
      RS_MASK_OR:  mask_d = mask_q | wdata;
      default:     mask_d = mask_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= '0;
      mask_q  <= '1;
    end else begin
      fault_q <= fault_d;
      mask_q  <= mask_d;
    end
  end

  for (genvar g = 0; g < NUM_ACT; g++) begin : g_act
    localparam reg_sel_e SEL = (g == 0) ? RS_ACT0 : RS_ACT1;
    always_ff @(posedge clk) begin
      if (rst)                act_q[g] <= '0;
      else if (wr_sel == SEL) act_q[g] <= wdata;
    end
  end

  always_comb begin
    case (rd_sel)
      RS_FAULT: rd_val = fault_q;
      RS_MASK:  rd_val = mask_q;
      RS_ACT0:  rd_val = act_q[0];
      RS_ACT1:  rd_val = act_q[NUM_ACT-1];
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= rd_val;
      rvalid <= rd_en;
    end
  end

  assert_reset_vals_R1: assert property (@(posedge clk)
    rst |=> (fault_q == '0 && mask_q == '1 && act_q == '0));

  assert_pulse_sticks_R2: assert property (@(posedge clk) disable iff (rst)
    (err_pulse != '0) |=> ((fault_q & $past(err_pulse)) == $past(err_pulse)));

  assert_hw_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_sel == RS_FAULT_AND || wr_sel == RS_FAULT) |=>
      ((fault_q & $past(err_pulse)) == $past(err_pulse)));

  assert_and_alias_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_sel == RS_FAULT_AND && err_pulse == '0) |=>
      (fault_q == ($past(fault_q) & $past(wdata))));

  assert_unmapped_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_sel == RS_NONE && err_pulse == '0) |=>
      ($stable(fault_q) && $stable(mask_q) && $stable(act_q)));

endmodule

// File: rtl/fir_attn_route.sv
module fir_attn_route #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] fault,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] act0,
  input  logic [W-1:0] act1,
  output logic         attn_chk,
  output logic         attn_rec,
  output logic         attn_loc
);

  logic [W-1:0] live;

  always_comb live = fault & ~mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      attn_chk <= 1'b0;
      attn_rec <= 1'b0;
      attn_loc <= 1'b0;
    end else begin
      attn_chk <= |(live & ~act0 & ~act1);
      attn_rec <= |(live & ~act0 &  act1);
      attn_loc <= |(live &  act0);
    end
  end

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (mask == '1) |=> !(attn_chk || attn_rec || attn_loc));

  assert_chk_source_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(attn_chk) |-> $past(|(fault & ~mask & ~act0 & ~act1)));

  assert_rec_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(attn_rec) |-> $past(|(fault & ~mask & ~act0 & act1)));

  assert_loc_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(attn_loc) |-> $past(|(fault & ~mask & act0)));

  assert_no_fault_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (fault == '0) |=> !(attn_chk || attn_rec || attn_loc));

endmodule

// File: rtl/fir_attn_top.sv
module fir_attn_top
  import fir_pkg::*;
#(
  parameter int W      = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              bus_rvalid,
  input  logic [W-1:0]      err_pulse,
  output logic              attn_checkstop,
  output logic              attn_recoverable,
  output logic              attn_local
);

  localparam int NUM_ACT = 2;

  reg_sel_e                    wr_sel, rd_sel;
  logic [W-1:0]                fault_q, mask_q;
  logic [NUM_ACT-1:0][W-1:0]   act_q;

  fir_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .wr_en  (bus_wr_en),
    .rd_en  (bus_rd_en),
    .wr_sel (wr_sel),
    .rd_sel (rd_sel)
  );

  fir_store #(.W(W), .NUM_ACT(NUM_ACT)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_sel    (wr_sel),
    .rd_sel    (rd_sel),
    .rd_en     (bus_rd_en),
    .wdata     (bus_wdata),
    .err_pulse (err_pulse),
    .fault_q   (fault_q),
    .mask_q    (mask_q),
    .act_q     (act_q),
    .rdata     (bus_rdata),
    .rvalid    (bus_rvalid)
  );

  fir_attn_route #(.W(W)) u_route (
    .clk      (clk),
    .rst      (rst),
    .fault    (fault_q),
    .mask     (mask_q),
    .act0     (act_q[0]),
    .act1     (act_q[1]),
    .attn_chk (attn_checkstop),
    .attn_rec (attn_recoverable),
    .attn_loc (attn_local)
  );

  assert_alias_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && (is_alias(rd_sel) || rd_sel == RS_NONE)) |=>
      (bus_rvalid && bus_rdata == '0));

endmodule

// File: tb/tb_fir_attn_top.sv
`timescale 1ns/1ps
module tb_fir_attn_top;

  localparam int W = 64;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr_en = 1'b0;
  logic              bus_rd_en = 1'b0;
  logic [W-1:0]      bus_wdata = '0;
  logic [W-1:0]      bus_rdata;
  logic              bus_rvalid;
  logic [W-1:0]      err_pulse = '0;
  logic              attn_checkstop, attn_recoverable, attn_local;

  always #2 clk = ~clk;

  fir_attn_top #(.W(W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .err_pulse(err_pulse),
    .attn_checkstop(attn_checkstop), .attn_recoverable(attn_recoverable),
    .attn_local(attn_local)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [W-1:0] m_fault, m_mask, m_a0, m_a1;

  function automatic logic [2:0] model_attn();
    logic [W-1:0] live;
    live = m_fault & ~m_mask;
    return {|(live & ~m_a0 & ~m_a1), |(live & ~m_a0 & m_a1), |(live & m_a0)};
  endfunction

  function automatic logic [W-1:0] model_read(input logic [7:0] a);
    case (a)
      8'h0A:   return m_fault;
      8'h0D:   return m_mask;
      8'h10:   return m_a0;
      8'h11:   return m_a1;
      default: return '0;
    endcase
  endfunction

  function automatic void model_step(input logic [7:0] a, input logic we,
                                     input logic [W-1:0] d, input logic [W-1:0] e);
    logic [W-1:0] f;
    f = m_fault;
    if (we) begin
      case (a)
        8'h0A: f = d;
        8'h0B: f = m_fault & d;
        8'h0C: f = m_fault | d;
        8'h0D: m_mask = d;
        8'h0E: m_mask = m_mask & d;
        8'h0F: m_mask = m_mask | d;
        8'h10: m_a0 = d;
        8'h11: m_a1 = d;
        default: ;
      endcase
    end
    m_fault = f | e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive after a falling edge, check after the next falling edge
  task automatic cyc(input logic [7:0] a, input logic we, input logic re,
                     input logic [W-1:0] d, input logic [W-1:0] e, input string tag);
    logic [2:0]   exp_attn;
    logic [W-1:0] exp_rd;
    bus_addr = a; bus_wr_en = we; bus_rd_en = re; bus_wdata = d; err_pulse = e;
    exp_attn = model_attn();
    exp_rd   = re ? model_read(a) : '0;
    @(posedge clk);
    model_step(a, we, d, e);
    @(negedge clk);
    check({attn_checkstop, attn_recoverable, attn_local} == exp_attn,
          {tag, " R11 attention"}, 64'({attn_checkstop, attn_recoverable, attn_local}),
          64'(exp_attn));
    if (re)
      check(bus_rvalid && bus_rdata == exp_rd, {tag, " R9 read"}, bus_rdata, exp_rd);
  endtask

  task automatic idle(); cyc(8'h00, 0, 0, '0, '0, "idle"); endtask

  task automatic rd_expect(input logic [7:0] a, input logic [W-1:0] exp, input string tag);
    cyc(a, 0, 1, '0, '0, tag);
    check(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251));
    m_fault = '0; m_mask = '1; m_a0 = '0; m_a1 = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    check({attn_checkstop, attn_recoverable, attn_local} == 3'b000, "R1 attn reset",
          64'({attn_checkstop, attn_recoverable, attn_local}), 64'd0);
    rd_expect(8'h0D, {W{1'b1}}, "R1 mask reset");
    rd_expect(8'h0A, '0, "R1 fault reset");
    rd_expect(8'h10, '0, "R1 act0 reset");
    rd_expect(8'h11, '0, "R1 act1 reset");

    // R2 sticky pulse while masked: no attention
    cyc(8'h00, 0, 0, '0, 64'h20, "R2 pulse");
    idle(); idle();
    rd_expect(8'h0A, 64'h20, "R2 sticky");
    check(!attn_checkstop, "R2 masked quiet", 64'(attn_checkstop), 64'd0);

    // R3 fault aliases
    cyc(8'h0C, 1, 0, 64'hF00, '0, "R3 or");
    rd_expect(8'h0A, 64'hF20, "R3 or result");
    cyc(8'h0B, 1, 0, ~64'h300, '0, "R3 and");
    rd_expect(8'h0A, 64'hC20, "R3 and result");

    // R5 hardware set beats AND clear
    cyc(8'h0B, 1, 0, ~64'h20, 64'h20, "R5 race");
    rd_expect(8'h0A, 64'hC20, "R5 bit kept");

    // R4 mask aliases and direct write
    cyc(8'h0E, 1, 0, ~64'h20, '0, "R4 mask and");
    rd_expect(8'h0D, ~64'h20, "R4 mask and result");
    // R6 checkstop on unmasked bit 5, both action bits clear
    idle();
    check(attn_checkstop && !attn_recoverable && !attn_local, "R6 checkstop",
          64'({attn_checkstop, attn_recoverable, attn_local}), 64'b100);

    // R7 recoverable
    cyc(8'h11, 1, 0, 64'h20, '0, "R7 act1");
    idle();
    check(!attn_checkstop && attn_recoverable && !attn_local, "R7 recoverable",
          64'({attn_checkstop, attn_recoverable, attn_local}), 64'b010);

    // R8 local
    cyc(8'h10, 1, 0, 64'h20, '0, "R8 act0");
    idle();
    check(!attn_checkstop && !attn_recoverable && attn_local, "R8 local",
          64'({attn_checkstop, attn_recoverable, attn_local}), 64'b001);

    cyc(8'h0F, 1, 0, 64'h20, '0, "R4 mask or");
    rd_expect(8'h0D, {W{1'b1}}, "R4 mask or result");
    cyc(8'h0D, 1, 0, 64'h0FF0, '0, "R4 mask write");
    rd_expect(8'h0D, 64'h0FF0, "R4 mask direct");

    // R9 alias and unmapped reads are zero
    rd_expect(8'h0B, '0, "R9 alias read");
    rd_expect(8'h0F, '0, "R9 alias read mask");
    rd_expect(8'h20, '0, "R9 unmapped read");

    // R10 unmapped write ignored
    cyc(8'h20, 1, 0, '1, '0, "R10 write");
    cyc(8'h09, 1, 0, '0, '0, "R10 write");
    rd_expect(8'h0A, 64'hC20, "R10 fault kept");
    rd_expect(8'h0D, 64'h0FF0, "R10 mask kept");
    rd_expect(8'h10, 64'h20, "R10 act0 kept");

    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]   a;
      logic [W-1:0] d, e;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel < 8) ? 8'(8'h0A + sel) : ((sel == 8) ? 8'h20 : 8'h09);
      d = {$urandom(), $urandom()};
      if (a == 8'h0D || a == 8'h0E) d = d | {$urandom(), $urandom()};
      e = ($urandom_range(0, 3) == 0) ? (64'd1 << $urandom_range(0, 63)) : '0;
      cyc(a, ($urandom_range(0, 1) == 1), ($urandom_range(0, 1) == 1), d, e, "R6 R7 R8 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule